// File: doc/BRIEF.md
# Staged Pipeline Control Propagation

This block is the control path of a five-stage in-order pipeline. The decode-stage instruction arrives as an opcode and a function field. A single main decoder turns it into the full set of datapath control signals. These signals are then carried forward through three pipeline registers: decode-to-execute, execute-to-memory and memory-to-writeback. In every cycle, each stage's outputs therefore belong only to the instruction that occupies that stage. The execute group is dropped once it has been used, and the memory group is dropped after the memory stage. Each register holds only what its downstream stages still consume.

External hazard logic, which is outside this block, steers the flow with one flush input per pipeline register and one stall input on the decode-to-execute register. A flush turns a slot into a bubble by clearing the three signals that change machine state: register write, memory write and branch. A stall holds the instruction that is in execute, and a bubble moves on into the memory stage behind it. Reset is synchronous and clears all staged control to the no-op encoding, which is all zeros.

Top module: `pctl_stager`

## Requirements
- R1: A load (opcode 0x23) decodes to ext_op=1, alu_src=1, alu_op=ADD (0), dst_sel=0, mem_wr=0, branch=0, mem_to_reg=1, reg_wr=1.
- R2: A store (opcode 0x2B) decodes to ext_op=1, alu_src=1, alu_op=ADD, dst_sel=0, mem_wr=1, branch=0, mem_to_reg=0, reg_wr=0.
- R3: A register-type instruction (opcode 0x00) decodes to ext_op=0, alu_src=0, dst_sel=1, mem_wr=0, branch=0, mem_to_reg=0, reg_wr=1. Its alu_op comes from the function field: 0x20 gives ADD (0), 0x22 gives SUB (1), 0x24 gives AND (2), 0x25 gives OR (3), 0x26 gives XOR (4) and 0x2A gives SLT (5).
- R4: A branch-if-equal (opcode 0x04) decodes to ext_op=1, alu_src=0, alu_op=SUB (1), dst_sel=0, branch=1, mem_wr=0, mem_to_reg=0, reg_wr=0.
- R5: Any other opcode, and a register-type opcode with an unlisted function field, decode to all zeros (no-op).
- R6: The execute-group outputs (ext_op, alu_src, alu_op, dst_sel) show the decode of the instruction presented one clock edge earlier.
- R7: The memory-group outputs (mem_wr, branch) show that instruction's values after two edges, and the writeback-group outputs (mem_to_reg, reg_wr) show them after three edges, when no flush or stall intervenes.
- R8: The writeback stage takes its values only from the memory stage. A flush of the memory-to-writeback register clears reg_wr and keeps mem_to_reg.
- R9: While reset is sampled high at an edge, every staged control output becomes 0 at that edge.
- R10: A flush of the decode-to-execute or execute-to-memory register clears mem_wr, branch and reg_wr in the captured slot, and every other field passes through unchanged.
- R11: A stall with no decode-to-execute flush keeps all decode-to-execute contents unchanged, and the execute-to-memory register captures a bubble: the held slot's fields with mem_wr, branch and reg_wr cleared.
- R12: When stall and decode-to-execute flush are both high, the flush wins: the new decode is captured as a bubble and the stall has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_funct | input | 6 | Function field of the instruction in decode |
| flush_idex | input | 1 | Bubble the decode-to-execute register |
| flush_exmem | input | 1 | Bubble the execute-to-memory register |
| flush_memwb | input | 1 | Bubble the memory-to-writeback register |
| stall_idex | input | 1 | Hold the decode-to-execute register |
| ex_ext_op | output | 1 | Sign-extend the immediate in execute |
| ex_alu_src | output | 1 | Execute second ALU operand: 1 immediate, 0 register |
| ex_alu_op | output | 3 | ALU operation in execute |
| ex_dst_sel | output | 1 | Destination field select: 1 rd, 0 rt |
| mem_wr | output | 1 | Memory write in memory stage |
| mem_branch | output | 1 | Branch resolve in memory stage |
| wb_mem_to_reg | output | 1 | Writeback source: 1 load data, 0 ALU result |
| wb_reg_wr | output | 1 | Register-file write in writeback |

## Verification
Every cycle, the assertions check that each register captures its upstream group one edge later when it is neither flushed nor stalled. They also check that a flush or stall leaves no state-changing signal set in the killed slot, that a stall keeps the execute slot stable, that the decoder never raises more than one of the three state-changing signals, and that reset lands on all zeros. Some behaviours only the bench's scenarios can show. These are the decode table values for each opcode and function field, the whole three-stage journey of a single instruction, and the interplay of random flush and stall patterns across a long instruction stream.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 3;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SLT = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic    ext_op;
    logic    alu_src;
    alu_op_e alu_op;
    logic    dst_sel;
  } ex_grp_t;

  typedef struct packed {
    logic mem_wr;
    logic branch;
  } mem_grp_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_grp_t;

  typedef struct packed {
    ex_grp_t  ex;
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctl_word_t;

  // Map a register-type function field to an ALU operation; valid=0 if unlisted.
  function automatic logic [ALU_W:0] rtype_alu(input logic [FN_W-1:0] fn);
    logic [ALU_W:0] r;
    unique case (fn)
      6'h20:   r = {1'b1, ALU_ADD};
      6'h22:   r = {1'b1, ALU_SUB};
      6'h24:   r = {1'b1, ALU_AND};
      6'h25:   r = {1'b1, ALU_OR};
      6'h26:   r = {1'b1, ALU_XOR};
      6'h2A:   r = {1'b1, ALU_SLT};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic ctl_word_t decode_ctl(input logic [OPC_W-1:0] opc,
                                           input logic [FN_W-1:0]  fn);
    ctl_word_t c;
    logic [ALU_W:0] ra;
    c  = '0;
    ra = rtype_alu(fn);
    unique case (opc)
      OPC_RTYPE: if (ra[ALU_W]) begin
        c.ex.alu_op  = alu_op_e'(ra[ALU_W-1:0]);
        c.ex.dst_sel = 1'b1;
        c.wb.reg_wr  = 1'b1;
      end
      OPC_LOAD: begin
        c.ex.ext_op     = 1'b1;
        c.ex.alu_src    = 1'b1;
        c.ex.alu_op     = ALU_ADD;
        c.wb.mem_to_reg = 1'b1;
        c.wb.reg_wr     = 1'b1;
      end
      OPC_STORE: begin
        c.ex.ext_op  = 1'b1;
        c.ex.alu_src = 1'b1;
        c.ex.alu_op  = ALU_ADD;
        c.mem.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        c.ex.ext_op  = 1'b1;
        c.ex.alu_op  = ALU_SUB;
        c.mem.branch = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic mem_grp_t kill_mem(input mem_grp_t m);
    mem_grp_t k;
    k = m;
    k.mem_wr = 1'b0;
    k.branch = 1'b0;
    return k;
  endfunction

  function automatic wb_grp_t kill_wb(input wb_grp_t w);
    wb_grp_t k;
    k = w;
    k.reg_wr = 1'b0;
    return k;
  endfunction

endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
  import pctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctl_word_t        ctl
);

  always_comb begin
    ctl = decode_ctl(opcode, funct);
  end

  // R5: at most one state-changing signal per decoded instruction
  always_comb begin
    a_r5_one_effect: assert ($onehot0({ctl.mem.mem_wr, ctl.mem.branch, ctl.wb.reg_wr}));
  end

endmodule

// File: rtl/pctl_idex.sv
module pctl_idex
  import pctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      stall,
  input  ctl_word_t d,
  output ex_grp_t   ex_q,
  output mem_grp_t  mem_q,
  output wb_grp_t   wb_q,
  output logic      hold
);

  logic flush_take;

  assign hold       = stall & ~flush;
  assign flush_take = flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else if (flush_take) begin
      ex_q  <= d.ex;
      mem_q <= kill_mem(d.mem);
      wb_q  <= kill_wb(d.wb);
    end else if (!hold) begin
      ex_q  <= d.ex;
      mem_q <= d.mem;
      wb_q  <= d.wb;
    end
  end

  a_r9_idex_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ex_q == '0 && mem_q == '0 && wb_q == '0));

  a_r6_ex_latency: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flush) && !$past(stall)) |-> (ex_q == $past(d.ex)));

  a_r12_flush_kills: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush)) |-> (!mem_q.mem_wr && !mem_q.branch && !wb_q.reg_wr));

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold)) |-> ($stable(ex_q) && $stable(mem_q) && $stable(wb_q)));

endmodule

// File: rtl/pctl_exmem.sv
module pctl_exmem
  import pctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     hold_up,
  input  mem_grp_t mem_d,
  input  wb_grp_t  wb_d,
  output mem_grp_t mem_q,
  output wb_grp_t  wb_q
);

  logic bubble;

  assign bubble = flush | hold_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
      wb_q  <= '0;
    end else if (bubble) begin
      mem_q <= kill_mem(mem_d);
      wb_q  <= kill_wb(wb_d);
    end else begin
      mem_q <= mem_d;
      wb_q  <= wb_d;
    end
  end

  a_r9_exmem_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_q == '0 && wb_q == '0));

  a_r7_mem_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flush) && !$past(hold_up)) |->
      (mem_q == $past(mem_d) && wb_q == $past(wb_d)));

  a_r11_stall_bubble: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold_up)) |-> (!mem_q.mem_wr && !mem_q.branch && !wb_q.reg_wr));

  a_r10_exmem_flush: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush)) |->
      (!mem_q.mem_wr && !mem_q.branch && !wb_q.reg_wr && wb_q.mem_to_reg == $past(wb_d.mem_to_reg)));

endmodule

// File: rtl/pctl_memwb.sv
module pctl_memwb
  import pctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    flush,
  input  wb_grp_t wb_d,
  output wb_grp_t wb_q
);

  always_ff @(posedge clk) begin
    if (rst)        wb_q <= '0;
    else if (flush) wb_q <= kill_wb(wb_d);
    else            wb_q <= wb_d;
  end

  a_r9_memwb_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wb_q == '0));

  a_r8_wb_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flush)) |-> (wb_q == $past(wb_d)));

  a_r8_wb_flush: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush)) |->
      (!wb_q.reg_wr && wb_q.mem_to_reg == $past(wb_d.mem_to_reg)));

endmodule

// File: rtl/pctl_stager.sv
module pctl_stager
  import pctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] id_opcode,
  input  logic [FN_W-1:0]  id_funct,
  input  logic             flush_idex,
  input  logic             flush_exmem,
  input  logic             flush_memwb,
  input  logic             stall_idex,
  output logic             ex_ext_op,
  output logic             ex_alu_src,
  output logic [ALU_W-1:0] ex_alu_op,
  output logic             ex_dst_sel,
  output logic             mem_wr,
  output logic             mem_branch,
  output logic             wb_mem_to_reg,
  output logic             wb_reg_wr
);

  ctl_word_t id_ctl;
  ex_grp_t   idex_ex;
  mem_grp_t  idex_mem;
  wb_grp_t   idex_wb;
  logic      idex_hold;
  mem_grp_t  exmem_mem;
  wb_grp_t   exmem_wb;
  wb_grp_t   memwb_wb;

  pctl_decode u_decode (
    .opcode (id_opcode),
    .funct  (id_funct),
    .ctl    (id_ctl)
  );

  pctl_idex u_idex (
    .clk   (clk),
    .rst   (rst),
    .flush (flush_idex),
    .stall (stall_idex),
    .d     (id_ctl),
    .ex_q  (idex_ex),
    .mem_q (idex_mem),
    .wb_q  (idex_wb),
    .hold  (idex_hold)
  );

  pctl_exmem u_exmem (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush_exmem),
    .hold_up (idex_hold),
    .mem_d   (idex_mem),
    .wb_d    (idex_wb),
    .mem_q   (exmem_mem),
    .wb_q    (exmem_wb)
  );

  pctl_memwb u_memwb (
    .clk   (clk),
    .rst   (rst),
    .flush (flush_memwb),
    .wb_d  (exmem_wb),
    .wb_q  (memwb_wb)
  );

  assign ex_ext_op     = idex_ex.ext_op;
  assign ex_alu_src    = idex_ex.alu_src;
  assign ex_alu_op     = idex_ex.alu_op;
  assign ex_dst_sel    = idex_ex.dst_sel;
  assign mem_wr        = exmem_mem.mem_wr;
  assign mem_branch    = exmem_mem.branch;
  assign wb_mem_to_reg = memwb_wb.mem_to_reg;
  assign wb_reg_wr     = memwb_wb.reg_wr;

  // R12: flush outranks stall, so the hold strobe never rises with a flush
  a_r12_no_hold_on_flush: assert property (@(posedge clk) disable iff (rst)
    flush_idex |-> !idex_hold);

endmodule

// File: tb/test_pctl_stager.sv
`timescale 1ns/1ps
module test_pctl_stager;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] id_opcode, id_funct;
  logic       flush_idex, flush_exmem, flush_memwb, stall_idex;
  logic       ex_ext_op, ex_alu_src, ex_dst_sel;
  logic [2:0] ex_alu_op;
  logic       mem_wr, mem_branch, wb_mem_to_reg, wb_reg_wr;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string tag    = "R9";

  // bench model: ex = {ext, src, op[2:0], dst}, mem = {wr, br}, wb = {m2r, rw}
  logic [5:0] m_idex_ex;
  logic [1:0] m_idex_mem, m_idex_wb, m_exmem_mem, m_exmem_wb, m_memwb_wb;

  always #2 clk = ~clk;

  pctl_stager i_pctl_stager (
    .clk(clk), .rst(rst), .id_opcode(id_opcode), .id_funct(id_funct),
    .flush_idex(flush_idex), .flush_exmem(flush_exmem), .flush_memwb(flush_memwb),
    .stall_idex(stall_idex), .ex_ext_op(ex_ext_op), .ex_alu_src(ex_alu_src),
    .ex_alu_op(ex_alu_op), .ex_dst_sel(ex_dst_sel), .mem_wr(mem_wr),
    .mem_branch(mem_branch), .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_wr(wb_reg_wr)
  );

  // Expected decode per R1..R5: {ext, src, op[2:0], dst, wr, br, m2r, rw}
  function automatic logic [9:0] exp_decode(input logic [5:0] op, input logic [5:0] fn);
    logic [2:0] a;
    bit ok;
    ok = 1'b1;
    case (fn)
      6'h20: a = 3'd0;  6'h22: a = 3'd1;  6'h24: a = 3'd2;
      6'h25: a = 3'd3;  6'h26: a = 3'd4;  6'h2A: a = 3'd5;
      default: begin a = 3'd0; ok = 1'b0; end
    endcase
    if (op == 6'h23)      return {1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    else if (op == 6'h2B) return {1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    else if (op == 6'h04) return {1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    else if (op == 6'h00 && ok) return {1'b0, 1'b0, a, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    return 10'd0;
  endfunction

  task automatic model_edge();
    logic [9:0] dc;
    bit hold;
    dc   = exp_decode(id_opcode, id_funct);
    hold = stall_idex && !flush_idex;
    if (rst) begin
      m_idex_ex = '0; m_idex_mem = '0; m_idex_wb = '0;
      m_exmem_mem = '0; m_exmem_wb = '0; m_memwb_wb = '0;
    end else begin
      m_memwb_wb = flush_memwb ? {m_exmem_wb[1], 1'b0} : m_exmem_wb;
      if (hold || flush_exmem) begin
        m_exmem_mem = 2'b00;
        m_exmem_wb  = {m_idex_wb[1], 1'b0};
      end else begin
        m_exmem_mem = m_idex_mem;
        m_exmem_wb  = m_idex_wb;
      end
      if (flush_idex) begin
        m_idex_ex = dc[9:4]; m_idex_mem = 2'b00; m_idex_wb = {dc[1], 1'b0};
      end else if (!hold) begin
        m_idex_ex = dc[9:4]; m_idex_mem = dc[3:2]; m_idex_wb = dc[1:0];
      end
    end
  endtask

  task automatic check_grp(input string grp, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, grp, act, exp);
    end
  endtask

  task automatic check_all();
    check_grp("R6 execute group", {ex_ext_op, ex_alu_src, ex_alu_op, ex_dst_sel}, m_idex_ex);
    check_grp("R7 memory group", {4'd0, mem_wr, mem_branch}, {4'd0, m_exmem_mem});
    check_grp("R8 writeback group", {4'd0, wb_mem_to_reg, wb_reg_wr}, {4'd0, m_memwb_wb});
  endtask

  task automatic step(input logic [5:0] op, input logic [5:0] fn,
                      input bit fi, input bit fe, input bit fw, input bit st);
    id_opcode = op; id_funct = fn;
    flush_idex = fi; flush_exmem = fe; flush_memwb = fw; stall_idex = st;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(6'h3F, 6'h00, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [5];
    logic [5:0] fns [7];
    ops = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h11};
    fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A, 6'h21};
    void'($urandom(32'd20241));
    rst = 1'b1;
    @(negedge clk);
    // R9: reset clears all stages
    tag = "R9";
    step(6'h23, 6'h00, 0, 0, 0, 0);
    step(6'h2B, 6'h00, 1, 1, 1, 1);
    step(6'h00, 6'h20, 0, 0, 0, 0);
    rst = 1'b0;
    tag = "R1"; step(6'h23, 6'h00, 0, 0, 0, 0); nops(3);   // load through all stages
    tag = "R2"; step(6'h2B, 6'h00, 0, 0, 0, 0); nops(3);
    tag = "R3";
    for (int i = 0; i < 6; i++) step(6'h00, fns[i], 0, 0, 0, 0);
    nops(3);
    tag = "R4"; step(6'h04, 6'h00, 0, 0, 0, 0); nops(3);
    tag = "R5";
    step(6'h00, 6'h21, 0, 0, 0, 0); step(6'h3A, 6'h20, 0, 0, 0, 0); nops(3);
    tag = "R10";
    step(6'h23, 6'h00, 1, 0, 0, 0); nops(3);
    step(6'h2B, 6'h00, 0, 0, 0, 0); step(6'h3F, 6'h00, 0, 1, 0, 0); nops(3);
    tag = "R8";
    step(6'h23, 6'h00, 0, 0, 0, 0); nops(1); step(6'h3F, 6'h00, 0, 0, 1, 0); nops(2);
    tag = "R11";
    step(6'h23, 6'h00, 0, 0, 0, 0);
    step(6'h2B, 6'h00, 0, 0, 0, 1); step(6'h04, 6'h00, 0, 0, 0, 1); nops(3);
    tag = "R12";
    step(6'h23, 6'h00, 0, 0, 0, 0); step(6'h2B, 6'h00, 1, 0, 0, 1); nops(3);
    // R6 R7 R8 under random streams
    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      step(ops[$urandom_range(4)], fns[$urandom_range(6)],
           ($urandom_range(7) == 0), ($urandom_range(9) == 0),
           ($urandom_range(9) == 0), ($urandom_range(5) == 0));
      if (n == 1500) begin
        rst = 1'b1; tag = "R9"; step(6'h23, 6'h00, 0, 0, 0, 0); rst = 1'b0; tag = "R7";
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule